// File: doc/BRIEF.md
# Link Reset Retry Controller

This block supervises hard resets on a serial storage port whose PHY does not always train on the first try with fast drives. A single reset request pulse starts the sequence. The block first asks the port's command engine to stop. It then writes a busy status byte into the received device-to-host status frame area, so a stale frame cannot pass for a new one. After that it runs one or more reset attempts. Each attempt lifts the lane overrides, performs the link hard reset, puts the lane overrides back, and reads the link status.

The loop ends when the link reports online, when the detect field shows no device, when the status read fails, or when the retry budget is spent. The engine is then restarted. A one-cycle done pulse reports the online flag and the return code of the last hard reset. Every external operation is a request/acknowledge pair: the request is registered and held high until the acknowledge is sampled.

Top module: `link_retry_ctrl`

## Requirements
- R1: After reset all request outputs, `done_o` and `online_o` are 0 and `rc_o` is 0.
- R2: A reset request raises the engine-stop request before any other request. The engine-start request is raised only after the status read of the final attempt has been acknowledged, and it is the last request of the run.
- R3: After the stop completes, the status-frame clear request is issued, with `fis_clr_data_o` equal to 8'h80 while it is high.
- R4: Each attempt issues, in this order and one at a time: override disable, hard reset, override enable, status read.
- R5: If the status read succeeds with detect bits [1:0] equal to 0, no further attempt follows.
- R6: If detect is nonzero and the last hard reset reported offline, another attempt follows. There are at most MAX_RETRY (default 10) retries, so at most 11 attempts.
- R7: If the status read returns `sts_err_i`=1, the loop ends at once, whatever the detect value and online flag are.
- R8: The loop ends after an attempt whose hard reset reported online. Completion of the engine start gives a one-cycle `done_o`, with `online_o` and `rc_o` taken from the last hard reset. These values hold until the next completion.
- R9: A reset request that arrives while a run is in progress is ignored: exactly one done pulse and one request sequence are produced.
- R10: At most one request is high at a time. A request stays high until its acknowledge is sampled, and drops in the cycle after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| go_i | input | 1 | Reset request pulse, taken only when idle |
| eng_stop_req_o | output | 1 | Command engine stop request |
| eng_stop_ack_i | input | 1 | Stop acknowledge |
| fis_clr_req_o | output | 1 | Status frame area write request |
| fis_clr_data_o | output | 8 | Status byte to write (busy, 8'h80) |
| fis_clr_ack_i | input | 1 | Frame write acknowledge |
| ovr_off_req_o | output | 1 | Lane override disable request |
| ovr_off_ack_i | input | 1 | Override disable acknowledge |
| hrst_req_o | output | 1 | Link hard reset request |
| hrst_ack_i | input | 1 | Hard reset acknowledge |
| hrst_online_i | input | 1 | Link online result, valid with acknowledge |
| hrst_rc_i | input | RC_W | Hard reset return code, valid with acknowledge |
| ovr_on_req_o | output | 1 | Lane override enable request |
| ovr_on_ack_i | input | 1 | Override enable acknowledge |
| sts_req_o | output | 1 | Link status read request |
| sts_ack_i | input | 1 | Status read acknowledge |
| sts_err_i | input | 1 | Status read failed, valid with acknowledge |
| sts_data_i | input | STS_W | Link status word; bits [1:0] are the detect field |
| eng_start_req_o | output | 1 | Command engine start request |
| eng_start_ack_i | input | 1 | Start acknowledge |
| done_o | output | 1 | One-cycle completion pulse |
| online_o | output | 1 | Online flag of the last attempt |
| rc_o | output | RC_W | Return code of the last hard reset |

## Verification
Directed cases cover each loop exit separately: online on the first attempt, no device on the first attempt, a failed status read while detect is nonzero and the link is offline, online on the final allowed retry, and all 11 attempts failing. These separate the exit conditions from the budget limit and expose off-by-one errors in the retry count. Random cases draw detect, online and read-error values per attempt, plus random acknowledge delays. They check the full request order against a model of the loop, and check that requests are held until acknowledged. One case sends a second reset request in the middle of a run, which shows whether the block ignores it or starts again.

// File: rtl/lrr_pkg.sv
package lrr_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_STOP,
    ST_CLEAR,
    ST_OVR_OFF,
    ST_HRST,
    ST_OVR_ON,
    ST_STATUS,
    ST_START
  } lrr_state_e;

  localparam int CH_STOP  = 0;
  localparam int CH_CLEAR = 1;
  localparam int CH_OFF   = 2;
  localparam int CH_HRST  = 3;
  localparam int CH_ON    = 4;
  localparam int CH_STS   = 5;
  localparam int CH_START = 6;
  localparam int NUM_CH   = 7;

  localparam logic [7:0] FRAME_BUSY_BYTE = 8'h80;

endpackage

// File: rtl/lrr_hs_chan.sv
module lrr_hs_chan (
  input  logic clk,
  input  logic rst,
  input  logic launch_i,
  input  logic ack_i,
  output logic req_o,
  output logic fin_o
);

  logic req_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q <= 1'b0;
    end else if (launch_i) begin
      req_q <= 1'b1;
    end else if (req_q && ack_i) begin
      req_q <= 1'b0;
    end
  end

  assign req_o = req_q;
  assign fin_o = req_q & ack_i;

endmodule

// File: rtl/lrr_retry_cnt.sv
module lrr_retry_cnt #(
  parameter int MAX_RETRY = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic load_i,
  input  logic dec_i,
  output logic zero_o
);

  localparam int CW = $clog2(MAX_RETRY + 1) + 1;
  localparam logic [CW-1:0] LOAD_VAL = CW'(MAX_RETRY);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= LOAD_VAL;
    end else if (dec_i && (cnt_q != '0)) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/lrr_attempt_judge.sv
module lrr_attempt_judge #(
  parameter int STS_W = 4
) (
  input  logic             rd_err_i,
  input  logic [STS_W-1:0] sts_i,
  input  logic             online_i,
  input  logic             budget_gone_i,
  output logic             stop_loop_o
);

  logic absent;

  assign absent = (sts_i[1:0] == 2'b00);

  always_comb begin
    if (rd_err_i)           stop_loop_o = 1'b1;
    else if (absent)        stop_loop_o = 1'b1;
    else if (online_i)      stop_loop_o = 1'b1;
    else if (budget_gone_i) stop_loop_o = 1'b1;
    else                    stop_loop_o = 1'b0;
  end

endmodule

// File: rtl/link_retry_ctrl.sv
module link_retry_ctrl #(
  parameter int MAX_RETRY = 10,
  parameter int RC_W      = 8,
  parameter int STS_W     = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            go_i,
  output logic            eng_stop_req_o,
  input  logic            eng_stop_ack_i,
  output logic            fis_clr_req_o,
  output logic [7:0]      fis_clr_data_o,
  input  logic            fis_clr_ack_i,
  output logic            ovr_off_req_o,
  input  logic            ovr_off_ack_i,
  output logic            hrst_req_o,
  input  logic            hrst_ack_i,
  input  logic            hrst_online_i,
  input  logic [RC_W-1:0] hrst_rc_i,
  output logic            ovr_on_req_o,
  input  logic            ovr_on_ack_i,
  output logic            sts_req_o,
  input  logic            sts_ack_i,
  input  logic            sts_err_i,
  input  logic [STS_W-1:0] sts_data_i,
  output logic            eng_start_req_o,
  input  logic            eng_start_ack_i,
  output logic            done_o,
  output logic            online_o,
  output logic [RC_W-1:0] rc_o
);
  import lrr_pkg::*;

  lrr_state_e state_q, state_d;
  logic [NUM_CH-1:0] launch, ack_vec, req_vec, fin;
  logic              cnt_load, cnt_dec, cnt_zero, stop_loop;
  logic              onl_cap_q;
  logic [RC_W-1:0]   rc_cap_q;
  logic              done_q, online_q;
  logic [RC_W-1:0]   rc_q;

  assign ack_vec[CH_STOP]  = eng_stop_ack_i;
  assign ack_vec[CH_CLEAR] = fis_clr_ack_i;
  assign ack_vec[CH_OFF]   = ovr_off_ack_i;
  assign ack_vec[CH_HRST]  = hrst_ack_i;
  assign ack_vec[CH_ON]    = ovr_on_ack_i;
  assign ack_vec[CH_STS]   = sts_ack_i;
  assign ack_vec[CH_START] = eng_start_ack_i;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
    lrr_hs_chan u_chan (
      .clk      (clk),
      .rst      (rst),
      .launch_i (launch[g]),
      .ack_i    (ack_vec[g]),
      .req_o    (req_vec[g]),
      .fin_o    (fin[g])
    );
  end

  assign eng_stop_req_o  = req_vec[CH_STOP];
  assign fis_clr_req_o   = req_vec[CH_CLEAR];
  assign ovr_off_req_o   = req_vec[CH_OFF];
  assign hrst_req_o      = req_vec[CH_HRST];
  assign ovr_on_req_o    = req_vec[CH_ON];
  assign sts_req_o       = req_vec[CH_STS];
  assign eng_start_req_o = req_vec[CH_START];
  assign fis_clr_data_o  = FRAME_BUSY_BYTE;

  lrr_retry_cnt #(.MAX_RETRY(MAX_RETRY)) u_cnt (
    .clk    (clk),
    .rst    (rst),
    .load_i (cnt_load),
    .dec_i  (cnt_dec),
    .zero_o (cnt_zero)
  );

  lrr_attempt_judge #(.STS_W(STS_W)) u_judge (
    .rd_err_i      (sts_err_i),
    .sts_i         (sts_data_i),
    .online_i      (onl_cap_q),
    .budget_gone_i (cnt_zero),
    .stop_loop_o   (stop_loop)
  );

  always_comb begin
    state_d  = state_q;
    launch   = '0;
    cnt_load = 1'b0;
    cnt_dec  = 1'b0;
    unique case (state_q)
      ST_IDLE: if (go_i) begin
        launch[CH_STOP] = 1'b1;
        cnt_load        = 1'b1;
        state_d         = ST_STOP;
      end
      ST_STOP: if (fin[CH_STOP]) begin
        launch[CH_CLEAR] = 1'b1;
        state_d          = ST_CLEAR;
      end
      ST_CLEAR: if (fin[CH_CLEAR]) begin
        launch[CH_OFF] = 1'b1;
        state_d        = ST_OVR_OFF;
      end
      ST_OVR_OFF: if (fin[CH_OFF]) begin
        launch[CH_HRST] = 1'b1;
        state_d         = ST_HRST;
      end
      ST_HRST: if (fin[CH_HRST]) begin
        launch[CH_ON] = 1'b1;
        state_d       = ST_OVR_ON;
      end
      ST_OVR_ON: if (fin[CH_ON]) begin
        launch[CH_STS] = 1'b1;
        state_d        = ST_STATUS;
      end
      ST_STATUS: if (fin[CH_STS]) begin
        if (stop_loop) begin
          launch[CH_START] = 1'b1;
          state_d          = ST_START;
        end else begin
          cnt_dec        = 1'b1;
          launch[CH_OFF] = 1'b1;
          state_d        = ST_OVR_OFF;
        end
      end
      ST_START: if (fin[CH_START]) begin
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      onl_cap_q <= 1'b0;
      rc_cap_q  <= '0;
      done_q    <= 1'b0;
      online_q  <= 1'b0;
      rc_q      <= '0;
    end else begin
      state_q <= state_d;
      done_q  <= 1'b0;
      if (state_q == ST_HRST && fin[CH_HRST]) begin
        onl_cap_q <= hrst_online_i;
        rc_cap_q  <= hrst_rc_i;
      end
      if (state_q == ST_START && fin[CH_START]) begin
        done_q   <= 1'b1;
        online_q <= onl_cap_q;
        rc_q     <= rc_cap_q;
      end
    end
  end

  assign done_o   = done_q;
  assign online_o = online_q;
  assign rc_o     = rc_q;

endmodule

// File: rtl/lrr_checker.sv
module lrr_checker #(
  parameter int MAX_RETRY = 10
) (
  input logic clk,
  input logic rst,
  input logic eng_stop_req_o,
  input logic fis_clr_req_o,
  input logic ovr_off_req_o,
  input logic ovr_off_ack_i,
  input logic hrst_req_o,
  input logic hrst_ack_i,
  input logic ovr_on_req_o,
  input logic sts_req_o,
  input logic sts_ack_i,
  input logic eng_start_req_o,
  input logic done_o
);

  logic [6:0] reqs;
  logic [7:0] att_cnt;
  logic       stop_d, hrst_d;

  assign reqs = {eng_start_req_o, sts_req_o, ovr_on_req_o, hrst_req_o,
                 ovr_off_req_o, fis_clr_req_o, eng_stop_req_o};

  always_ff @(posedge clk) begin
    if (rst) begin
      att_cnt <= '0;
      stop_d  <= 1'b0;
      hrst_d  <= 1'b0;
    end else begin
      stop_d <= eng_stop_req_o;
      hrst_d <= hrst_req_o;
      if (eng_stop_req_o && !stop_d) att_cnt <= '0;
      else if (hrst_req_o && !hrst_d) att_cnt <= att_cnt + 1'b1;
    end
  end

  AST_ONE_REQ: assert property (@(posedge clk) disable iff (rst)
    $onehot0(reqs)); // R10

  AST_HRST_HOLD: assert property (@(posedge clk) disable iff (rst)
    hrst_req_o && !hrst_ack_i |=> hrst_req_o); // R10

  AST_STS_HOLD: assert property (@(posedge clk) disable iff (rst)
    sts_req_o && !sts_ack_i |=> sts_req_o); // R10

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o); // R8

  AST_ATTEMPT_CAP: assert property (@(posedge clk) disable iff (rst)
    att_cnt <= 8'(MAX_RETRY + 1)); // R6

  AST_START_AFTER_STS: assert property (@(posedge clk) disable iff (rst)
    $rose(eng_start_req_o) |-> $past(sts_req_o && sts_ack_i)); // R2

  AST_OFF_BEFORE_HRST: assert property (@(posedge clk) disable iff (rst)
    $rose(hrst_req_o) |-> $past(ovr_off_req_o && ovr_off_ack_i)); // R4

endmodule

bind link_retry_ctrl lrr_checker #(.MAX_RETRY(MAX_RETRY)) u_lrr_chk (
  .clk             (clk),
  .rst             (rst),
  .eng_stop_req_o  (eng_stop_req_o),
  .fis_clr_req_o   (fis_clr_req_o),
  .ovr_off_req_o   (ovr_off_req_o),
  .ovr_off_ack_i   (ovr_off_ack_i),
  .hrst_req_o      (hrst_req_o),
  .hrst_ack_i      (hrst_ack_i),
  .ovr_on_req_o    (ovr_on_req_o),
  .sts_req_o       (sts_req_o),
  .sts_ack_i       (sts_ack_i),
  .eng_start_req_o (eng_start_req_o),
  .done_o          (done_o)
);

// File: tb/link_retry_ctrl_tb_top.sv
`timescale 1ns/1ps
module link_retry_ctrl_tb_top;
  localparam int MAXR  = 10;
  localparam int RC_W  = 8;
  localparam int STS_W = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic go  = 1'b0;
  logic [6:0] reqv;
  logic [6:0] ackv = '0;
  logic [7:0] fis_data;
  logic hrst_onl = 1'b0;
  logic [RC_W-1:0] hrst_rc = '0;
  logic sts_err = 1'b0;
  logic [STS_W-1:0] sts_dat = '0;
  logic done, online;
  logic [RC_W-1:0] rc;

  int checks = 0, errors = 0, cycles = 0, dn_cnt = 0;
  int att = 0, log_n = 0, hold_bad = 0, fis_bad = 0, multi_bad = 0;
  int log_q [0:63];
  int dly [0:6];
  bit seen [0:6];
  bit sc_onl [0:15];
  bit sc_err [0:15];
  logic [1:0] sc_det [0:15];

  always #5 clk = ~clk;

  link_retry_ctrl #(.MAX_RETRY(MAXR), .RC_W(RC_W), .STS_W(STS_W)) dut_i (
    .clk(clk), .rst(rst), .go_i(go),
    .eng_stop_req_o(reqv[0]), .eng_stop_ack_i(ackv[0]),
    .fis_clr_req_o(reqv[1]), .fis_clr_data_o(fis_data), .fis_clr_ack_i(ackv[1]),
    .ovr_off_req_o(reqv[2]), .ovr_off_ack_i(ackv[2]),
    .hrst_req_o(reqv[3]), .hrst_ack_i(ackv[3]),
    .hrst_online_i(hrst_onl), .hrst_rc_i(hrst_rc),
    .ovr_on_req_o(reqv[4]), .ovr_on_ack_i(ackv[4]),
    .sts_req_o(reqv[5]), .sts_ack_i(ackv[5]),
    .sts_err_i(sts_err), .sts_data_i(sts_dat),
    .eng_start_req_o(reqv[6]), .eng_start_ack_i(ackv[6]),
    .done_o(done), .online_o(online), .rc_o(rc)
  );

  always @(posedge clk) begin
    cycles++;
    if (!rst && done) dn_cnt++;
  end

  // responders: channel ids 0 stop,1 clear,2 off,3 hrst,4 on,5 status,6 start
  always @(negedge clk) begin
    if (!rst) begin
      if ($countones(reqv) > 1) multi_bad++;
      for (int ch = 0; ch < 7; ch++) begin
        if (ackv[ch]) begin
          ackv[ch] = 1'b0;
          seen[ch] = 1'b0;
        end else if (reqv[ch]) begin
          if (!seen[ch]) begin
            seen[ch] = 1'b1;
            if (log_n < 64) log_q[log_n] = ch;
            log_n++;
            dly[ch] = int'($urandom % 4);
          end
          if (ch == 1 && fis_data != 8'h80) fis_bad++;
          if (dly[ch] == 0) begin
            ackv[ch] = 1'b1;
            if (ch == 3) begin
              hrst_onl = sc_onl[att & 15];
              hrst_rc  = RC_W'(5 + att);
              att++;
            end
            if (ch == 5) begin
              sts_err = sc_err[(att - 1) & 15];
              sts_dat = {2'b10, sc_det[(att - 1) & 15]};
            end
          end else begin
            dly[ch]--;
          end
        end else if (seen[ch]) begin
          hold_bad++;
          seen[ch] = 1'b0;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  function automatic int model_attempts();
    for (int i = 0; i <= MAXR; i++) begin
      if (sc_err[i] || sc_det[i] == 2'b00 || sc_onl[i]) return i + 1;
    end
    return MAXR + 1;
  endfunction

  task automatic run_case(input string tag, input bit extra_go);
    int n, last, d0, to, exp_len;
    bit seq_ok;
    n = model_attempts();
    last = n - 1;
    log_n = 0; att = 0; d0 = dn_cnt;
    @(negedge clk); go = 1'b1;
    @(negedge clk); go = 1'b0;
    if (extra_go) begin
      repeat (3) @(negedge clk);
      go = 1'b1;
      @(negedge clk); go = 1'b0;
    end
    to = 0;
    while (!done && to < 3000) begin @(negedge clk); to++; end
    chk(done === 1'b1, {tag, " R8 done seen"}, done, 1);
    chk(online === sc_onl[last], {tag, " R8 online"}, online, sc_onl[last]);
    chk(rc === RC_W'(5 + last), {tag, " R8 rc"}, rc, 5 + last);
    chk(att == n, {tag, " R5 R6 R7 attempts"}, att, n);
    exp_len = 3 + 4 * n;
    seq_ok = (log_n == exp_len) && (log_q[0] == 0) && (log_q[1] == 1)
             && (log_q[exp_len - 1] == 6);
    for (int a = 0; a < n; a++)
      for (int k = 0; k < 4; k++)
        if (2 + 4 * a + k < 64 && log_q[2 + 4 * a + k] != 2 + k) seq_ok = 1'b0;
    chk(seq_ok, {tag, " R2 R3 R4 request order"}, log_n, exp_len);
    @(negedge clk);
    chk(done === 1'b0, {tag, " R8 done one cycle"}, done, 0);
    chk(online === sc_onl[last] && rc === RC_W'(5 + last), {tag, " R8 result held"}, rc, 5 + last);
    repeat (12) @(negedge clk);
    chk(dn_cnt - d0 == 1, {tag, " R9 single done"}, dn_cnt - d0, 1);
    chk(hold_bad == 0 && multi_bad == 0, {tag, " R10 handshake"}, hold_bad + multi_bad, 0);
    chk(fis_bad == 0, {tag, " R3 busy byte"}, fis_bad, 0);
  endtask

  task automatic fill(input bit onl, input logic [1:0] det, input bit er);
    for (int i = 0; i < 16; i++) begin
      sc_onl[i] = onl; sc_det[i] = det; sc_err[i] = er;
    end
  endtask

  initial begin
    void'($urandom(32'd4242));
    for (int c = 0; c < 7; c++) begin dly[c] = 0; seen[c] = 1'b0; end
    fill(1'b0, 2'b01, 1'b0);
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(reqv === 7'b0 && done === 1'b0, "R1 reset requests/done", reqv, 0);
    chk(online === 1'b0 && rc === '0, "R1 reset result", rc, 0);

    fill(1'b1, 2'b11, 1'b0);            run_case("online first", 1'b0);   // R8
    fill(1'b0, 2'b00, 1'b0);            run_case("no device", 1'b0);      // R5
    fill(1'b0, 2'b01, 1'b1);            run_case("read error", 1'b0);     // R7
    fill(1'b0, 2'b01, 1'b0);            run_case("exhausted", 1'b0);      // R6
    fill(1'b0, 2'b11, 1'b0); sc_onl[10] = 1'b1;
                                        run_case("last retry online", 1'b0); // R6
    fill(1'b0, 2'b01, 1'b0); sc_onl[2] = 1'b1;
                                        run_case("busy go", 1'b1);        // R9

    for (int r = 0; r < 30; r++) begin
      for (int i = 0; i < 16; i++) begin
        sc_onl[i] = ($urandom % 6) == 0;
        sc_det[i] = (($urandom % 8) == 0) ? 2'b00 : 2'(1 + $urandom % 3);
        sc_err[i] = ($urandom % 12) == 0;
      end
      run_case($sformatf("random %0d", r), ($urandom % 4) == 0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    errors++; checks++;
    $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule